// File: doc/BRIEF.md
# SDRAM Bank State Command Checker

This block watches a stream of already decoded SDRAM commands and keeps a model of the four banks. For each bank it records whether the bank is idle or holds an open row, and which row that is. It also holds the last value written to the mode register. Each incoming command is judged against that model and against two recovery timers. One timer runs per bank and sets the minimum gap from a precharge to the next activate. The other is shared and sets the gap after a mode load. An illegal command produces a one-cycle violation pulse with a reason code and leaves every piece of tracked state untouched.

Reads and writes can ask for an automatic precharge through address bit 10. The bank then closes by itself once the burst is over. The burst length comes from the stored mode value. A precharge command uses the same bit to choose between closing every bank and closing only the addressed one. The block sits beside a memory controller or a bus monitor as a protocol watchdog. It transfers no data.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset every bank reads idle with row 0, the mode value is 0, no violation is flagged, and both recovery timers are expired.
- R2: An ACTIVE to an idle bank opens it with the row taken from addr_i[11:0]. An ACTIVE to an active bank with a different row is a violation with reason 1. An ACTIVE with the same row as the open one has no effect and raises no violation.
- R3: A READ or WRITE to an idle bank is a violation with reason 2.
- R4: A READ or WRITE with addr_i[10]=1 closes its bank exactly BL cycles after the command is sampled. With addr_i[10]=0 the bank stays open.
- R5: The burst length BL is decoded from mode bits [2:0]: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and any other value gives 1.
- R6: A PRECHARGE with addr_i[10]=1 closes all banks and ignores bank_i. With addr_i[10]=0 it closes only bank bank_i. A precharge aimed at an idle bank leaves that bank and its timer unchanged.
- R7: An ACTIVE to a bank fewer than tRP cycles (trp_cfg_i, with 0 treated as 1) after that bank was closed, whether by an explicit or an automatic precharge, is a violation with reason 4. The same ACTIVE exactly tRP cycles after the close is accepted.
- R8: A LOAD MODE while any bank is active is a violation with reason 3, and the mode value is left unchanged.
- R9: Any command other than NOP issued fewer than tMRD cycles (tmrd_cfg_i, with 0 treated as 1) after an accepted LOAD MODE is a violation with reason 5. This reason takes priority over every other reason.
- R10: An accepted LOAD MODE stores addr_i[11:0] as the mode value. No other command alters it.
- R11: viol_o and viol_code_o appear in the cycle after the offending command and last one cycle. A rejected command changes no bank, timer or mode state. Reason codes: 0 none, 1 wrong row, 2 idle access, 3 mode load while busy, 4 tRP, 5 tMRD.
- R12: Command codes on cmd_i are 0 NOP, 1 LOAD MODE, 2 ACTIVE, 3 READ, 4 WRITE and 5 PRECHARGE. Codes 6 and 7 behave as NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Decoded command code |
| bank_i | input | BA_W | Bank address |
| addr_i | input | ROW_W | Row, column or mode value; bit 10 is the auto/all-bank flag |
| trp_cfg_i | input | TW | Precharge-to-activate gap in cycles |
| tmrd_cfg_i | input | TW | Gap after a mode load, in cycles |
| bank_active_o | output | 2**BA_W | Per-bank open flag |
| bank_row_o | output | 2**BA_W*ROW_W | Open row of bank b at bits [b*ROW_W +: ROW_W] |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_code_o | output | 3 | Reason for the violation |
| mode_o | output | ROW_W | Stored mode value |

## Verification
The assertions check four things on every cycle. An open bank's row never changes while the bank stays open. The mode value moves only after an accepted load, and only while every bank was idle. An ACTIVE to a recovering bank, an access to an idle bank, and any command inside the mode-load window each produce their reason one cycle later. The bench's scenarios are the only way to show the timing that needs counted cycles: that an automatic precharge closes the bank after exactly 1, 4 or 8 cycles, and that tRP counts from the end of the burst. They also show that precharging all banks ignores the bank bits, and that rejected commands leave the banks unchanged.

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker #(
  parameter int BA_W  = 2,
  parameter int ROW_W = 12,
  parameter int TW    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [2:0]                    cmd_i,
  input  logic [BA_W-1:0]               bank_i,
  input  logic [ROW_W-1:0]              addr_i,
  input  logic [TW-1:0]                 trp_cfg_i,
  input  logic [TW-1:0]                 tmrd_cfg_i,
  output logic [(1<<BA_W)-1:0]          bank_active_o,
  output logic [(1<<BA_W)*ROW_W-1:0]    bank_row_o,
  output logic                          viol_o,
  output logic [2:0]                    viol_code_o,
  output logic [ROW_W-1:0]              mode_o
);
  localparam int NB = 1 << BA_W;
  localparam logic [2:0] C_LMR = 3'd1, C_ACT = 3'd2, C_RD = 3'd3, C_WR = 3'd4, C_PRE = 3'd5;
  localparam logic [2:0] V_NONE = 3'd0, V_ROW = 3'd1, V_IDLE = 3'd2, V_BUSY = 3'd3,
                         V_TRP = 3'd4, V_MRD = 3'd5;

  logic             act_q  [NB];
  logic [ROW_W-1:0] row_q  [NB];
  logic [3:0]       bcnt_q [NB];
  logic             ap_q   [NB];
  logic [TW-1:0]    trp_q  [NB];
  logic [TW-1:0]    mrd_q;
  logic [ROW_W-1:0] mode_q;
  logic             viol_q;
  logic [2:0]       code_q, code_n;
  logic             any_act;

  wire is_exec = (cmd_i >= C_LMR) && (cmd_i <= C_PRE);
  wire is_acc  = (cmd_i == C_RD) || (cmd_i == C_WR);
  wire ap_bit  = addr_i[10];
  wire ok      = (code_n == V_NONE);

  wire [3:0] blen = (mode_q[2:0] == 3'd1) ? 4'd2 :
                    (mode_q[2:0] == 3'd2) ? 4'd4 :
                    (mode_q[2:0] == 3'd3) ? 4'd8 : 4'd1;
  wire [TW-1:0] trp_ld = (trp_cfg_i  > TW'(1)) ? trp_cfg_i  - TW'(1) : '0;
  wire [TW-1:0] mrd_ld = (tmrd_cfg_i > TW'(1)) ? tmrd_cfg_i - TW'(1) : '0;

  always_comb begin
    any_act = 1'b0;
    for (int b = 0; b < NB; b++) any_act = any_act | act_q[b];
  end

  always_comb begin
    code_n = V_NONE;
    if (is_exec && mrd_q != '0) code_n = V_MRD;
    else if (cmd_i == C_ACT) begin
      if (act_q[bank_i]) begin
        if (row_q[bank_i] != addr_i) code_n = V_ROW;
      end else if (trp_q[bank_i] != '0) code_n = V_TRP;
    end
    else if (is_acc && !act_q[bank_i]) code_n = V_IDLE;
    else if (cmd_i == C_LMR && any_act) code_n = V_BUSY;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        act_q[b] <= 1'b0; row_q[b] <= '0; bcnt_q[b] <= '0; ap_q[b] <= 1'b0; trp_q[b] <= '0;
      end
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (trp_q[b] != '0)  trp_q[b]  <= trp_q[b] - TW'(1);
        if (bcnt_q[b] != '0) bcnt_q[b] <= bcnt_q[b] - 4'd1;
        if (bcnt_q[b] == 4'd1 && ap_q[b]) begin
          act_q[b] <= 1'b0;
          trp_q[b] <= trp_ld;
        end
        if (ok && bank_i == b[BA_W-1:0]) begin
          if (cmd_i == C_ACT && !act_q[b]) begin
            act_q[b] <= 1'b1;
            row_q[b] <= addr_i;
          end
          if (is_acc) begin
            act_q[b]  <= 1'b1;
            trp_q[b]  <= '0;
            bcnt_q[b] <= blen;
            ap_q[b]   <= ap_bit;
          end
        end
        if (ok && cmd_i == C_PRE && act_q[b] && (ap_bit || bank_i == b[BA_W-1:0])) begin
          act_q[b]  <= 1'b0;
          trp_q[b]  <= trp_ld;
          bcnt_q[b] <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mrd_q  <= '0;
      mode_q <= '0;
      viol_q <= 1'b0;
      code_q <= V_NONE;
    end else begin
      if (mrd_q != '0) mrd_q <= mrd_q - TW'(1);
      if (ok && cmd_i == C_LMR) begin
        mode_q <= addr_i;
        mrd_q  <= mrd_ld;
      end
      viol_q <= !ok;
      code_q <= code_n;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_out
    assign bank_active_o[g] = act_q[g];
    assign bank_row_o[g*ROW_W +: ROW_W] = row_q[g];

    a_r2_open_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
      act_q[g] && $past(act_q[g]) |-> $stable(row_q[g]));
  end

  assign viol_o      = viol_q;
  assign viol_code_o = code_q;
  assign mode_o      = mode_q;

  a_r10_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i != C_LMR) |=> $stable(mode_q));

  a_r8_mode_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> !$past(any_act));

  a_r3_idle_access: assert property (@(posedge clk) disable iff (!rst_n)
    is_acc && !act_q[bank_i] && mrd_q == '0 |=> viol_o && viol_code_o == V_IDLE);

  a_r7_trp_guard: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i == C_ACT && !act_q[bank_i] && trp_q[bank_i] != '0 && mrd_q == '0
    |=> viol_o && viol_code_o == V_TRP);

  a_r9_mrd_guard: assert property (@(posedge clk) disable iff (!rst_n)
    is_exec && mrd_q != '0 |=> viol_o && viol_code_o == V_MRD);
endmodule

// File: tb/tb_sdram_bank_tracker.sv
module tb_sdram_bank_tracker;
  localparam int BA_W = 2, ROW_W = 12, TW = 4;
  localparam logic [2:0] NOP = 0, LMR = 1, ACT = 2, RD = 3, WR = 4, PRE = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cmd_i = NOP;
  logic [BA_W-1:0] bank_i = '0;
  logic [ROW_W-1:0] addr_i = '0;
  logic [TW-1:0] trp_cfg_i = 4'd3, tmrd_cfg_i = 4'd2;
  logic [3:0] bank_active_o;
  logic [4*ROW_W-1:0] bank_row_o;
  logic viol_o;
  logic [2:0] viol_code_o;
  logic [ROW_W-1:0] mode_o;
  int n_chk = 0, n_fail = 0;

  sdram_bank_tracker #(.BA_W(BA_W), .ROW_W(ROW_W), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .addr_i(addr_i),
    .trp_cfg_i(trp_cfg_i), .tmrd_cfg_i(tmrd_cfg_i), .bank_active_o(bank_active_o),
    .bank_row_o(bank_row_o), .viol_o(viol_o), .viol_code_o(viol_code_o), .mode_o(mode_o));

  always #2 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] c, int b, int a);
    cmd_i = c; bank_i = b[BA_W-1:0]; addr_i = a[ROW_W-1:0];
    @(posedge clk); #1;
    cmd_i = NOP;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  function automatic int rowof(int b);
    return int'(bank_row_o[b*ROW_W +: ROW_W]);
  endfunction

  task automatic t_reset;
    chk("R1 active", bank_active_o, 0);
    chk("R1 viol", viol_o, 0);
    chk("R1 mode", mode_o, 0);
    chk("R1 row", rowof(3), 0);
  endtask

  task automatic t_activate;
    issue(ACT, 1, 'h123);
    chk("R2 open", bank_active_o[1], 1);
    chk("R2 row", rowof(1), 'h123);
    chk("R2 no viol", viol_o, 0);
    issue(ACT, 1, 'h055);
    chk("R2 wrong row code", viol_code_o, 1);
    chk("R11 rejected keeps row", rowof(1), 'h123);
    idle(1);
    chk("R11 one-cycle pulse", viol_o, 0);
    issue(ACT, 1, 'h123);
    chk("R2 same row ok", viol_o, 0);
  endtask

  task automatic t_idle_access;
    issue(RD, 2, 0);
    chk("R3 read idle code", viol_code_o, 2);
    chk("R11 read idle no open", bank_active_o[2], 0);
    issue(WR, 3, 0);
    chk("R3 write idle code", viol_code_o, 2);
  endtask

  task automatic t_precharge;
    issue(ACT, 0, 1);
    issue(ACT, 2, 2);
    issue(PRE, 0, 0);
    chk("R6 single close", bank_active_o, 4'b0110);
    issue(PRE, 0, 'h400);
    chk("R6 all close ignores bank", bank_active_o, 0);
    idle(3);
  endtask

  task automatic t_trp;
    issue(ACT, 0, 7);
    chk("R7 act ok", viol_o, 0);
    issue(PRE, 0, 0);
    issue(ACT, 0, 7);
    chk("R7 gap 1", viol_code_o, 4);
    chk("R11 tRP reject keeps idle", bank_active_o[0], 0);
    issue(ACT, 0, 7);
    chk("R7 gap 2", viol_code_o, 4);
    issue(ACT, 0, 7);
    chk("R7 gap 3 accepted", viol_o, 0);
    chk("R7 gap 3 open", bank_active_o[0], 1);
  endtask

  task automatic t_autopre;
    issue(RD, 0, 'h400);
    chk("R5 BL1 still open", bank_active_o[0], 1);
    idle(1);
    chk("R4 BL1 closed", bank_active_o[0], 0);
    issue(LMR, 0, 3);
    chk("R10 mode loaded", mode_o, 3);
    idle(1);
    issue(ACT, 1, 9);
    issue(WR, 1, 'h400);
    idle(7);
    chk("R5 BL8 open at 7", bank_active_o[1], 1);
    idle(1);
    chk("R4 BL8 closed at 8", bank_active_o[1], 0);
    issue(ACT, 1, 9);
    chk("R7 auto tRP from burst end", viol_code_o, 4);
    idle(1);
    issue(ACT, 1, 9);
    chk("R7 auto tRP met", viol_o, 0);
    issue(RD, 1, 0);
    idle(9);
    chk("R4 no auto stays open", bank_active_o[1], 1);
  endtask

  task automatic t_lmr;
    issue(LMR, 0, 'h021);
    chk("R8 busy code", viol_code_o, 3);
    chk("R8 mode unchanged", mode_o, 3);
    issue(PRE, 0, 'h400);
    idle(3);
    issue(LMR, 0, 'h022);
    chk("R10 mode 22", mode_o, 'h022);
    issue(ACT, 2, 5);
    chk("R9 mrd code", viol_code_o, 5);
    chk("R9 act rejected", bank_active_o[2], 0);
    issue(ACT, 2, 5);
    chk("R9 after window", viol_o, 0);
    issue(RD, 2, 'h400);
    idle(3);
    chk("R5 BL4 open at 3", bank_active_o[2], 1);
    idle(1);
    chk("R5 BL4 closed at 4", bank_active_o[2], 0);
    chk("R10 mode kept", mode_o, 'h022);
  endtask

  task automatic t_spare_codes;
    issue(ACT, 3, 'h0AA);
    issue(3'd6, 3, 'h400);
    chk("R12 code 6 no viol", viol_o, 0);
    chk("R12 code 6 no close", bank_active_o[3], 1);
    issue(3'd7, 3, 'h011);
    chk("R12 code 7 row kept", rowof(3), 'h0AA);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset;
    t_activate;
    t_idle_access;
    t_precharge;
    t_trp;
    t_autopre;
    t_lmr;
    t_spare_codes;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule